// File: doc/BRIEF.md
# Flattened All-Pairs Sequencer with Per-Particle Accumulation

This block turns a doubly nested "every particle against every other particle" loop into one flat loop of N*(N-1) steps. On each step it offers a pair of indices to a downstream pipeline: a primary index and a partner index that never equals the primary. The pipeline returns one signed contribution per pair, in issue order. The block sums the contributions of each primary particle and presents that total after the particle's last partner.

Alongside the per-particle totals it keeps one energy total. The energy total takes a contribution only from pairs whose primary index is below the partner index and whose result is flagged as inside the cutoff radius, so each unordered pair is counted once. The particle count is captured when the run starts. The index stream honours a valid/ready handshake. A one-cycle done pulse follows the final energy value.

Top module: `pair_loop_fuser`

## Requirements
- R1: After reset, pair_valid, part_valid, energy_valid, done and busy are all 0.
- R2: n_count is captured only by a start pulse seen while busy is 0. A start pulse while busy is 1 has no effect on the run, and later changes of n_count have no effect either.
- R3: Issue step i (from 0) presents pair_j1 = i / (N-1). With r = i mod (N-1), it presents pair_j2 = r+1 when r >= pair_j1 and pair_j2 = r otherwise. Exactly N*(N-1) pairs are accepted per run, and pair_valid is 0 whenever busy is 0.
- R4: While pair_valid is 1, pair_j2 never equals pair_j1.
- R5: A pair is accepted on a clock edge where pair_valid and pair_ready are both 1. While pair_valid is 1 and pair_ready is 0, the indices hold and pair_valid stays 1.
- R6: Contributions are matched to pairs in issue order. Every run of N-1 contributions belonging to one primary index starts a fresh sum. In the cycle after the last of those N-1 contributions, part_valid is 1, part_idx is that primary index and part_sum is the sum.
- R7: Contributions are 32-bit two's complement values, sign-extended into 40-bit sums. Totals beyond the 32-bit range are reported exactly.
- R8: energy_sum is the sum of res_in_energy over the pairs with j1 < j2 and res_in_cut = 1. energy_valid pulses for one cycle in the cycle after the final contribution.
- R9: done pulses in the cycle after energy_valid, and busy is 0 in that cycle.
- R10: A start with n_count below 2 issues no pairs. It gives energy_valid with energy_sum = 0 in the next cycle and done in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start a run (ignored while busy) |
| n_count | input | IDX_W | Particle count N, captured at start |
| pair_ready | input | 1 | Downstream accepts the offered pair |
| res_in_valid | input | 1 | One returned contribution is present |
| res_in_force | input | DATA_W | Signed per-particle contribution |
| res_in_energy | input | DATA_W | Signed energy contribution |
| res_in_cut | input | 1 | Pair lies inside the cutoff |
| pair_valid | output | 1 | A pair is offered |
| pair_j1 | output | IDX_W | Primary index |
| pair_j2 | output | IDX_W | Partner index |
| part_valid | output | 1 | Per-particle total is present |
| part_idx | output | IDX_W | Particle of the total |
| part_sum | output | ACC_W | Per-particle total |
| energy_valid | output | 1 | Final energy is present |
| energy_sum | output | ACC_W | Energy total |
| done | output | 1 | Run complete pulse |
| busy | output | 1 | Run in progress |

## Verification
The first scenario uses a free-flowing index stream with immediate returns, which sets the ordering baseline. A second scenario adds periodic ready stalls and returns every other cycle. It separates the issue counters from the return-side tracking, since the two then drift apart by several pairs. Near-full-scale contributions tell a 40-bit sum from one that wraps at 32 bits. A cutoff pattern with mixed-sign energies tells the j1 < j2 filter from an unfiltered sum. N of 0, 1 and 2 cover the degenerate runs, and a start pulse in the middle of a run, with n_count changed afterwards, probes the capture rule.

// File: rtl/fpair_pkg.sv
// Shared types for the fused pair sequencer.
package fpair_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FLUSH = 2'd3
    } seq_state_t;
endpackage

// File: rtl/fpair_walker.sv
// Flat pair walker: one inner counter (0..last_k, wrapping) and a primary
// index that steps whenever the inner counter wraps. The partner index is the
// inner count bumped by one once it reaches the primary index.
// Assumes last_k = N-2 is stable for the whole run and N >= 2.
module fpair_walker #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [IDX_W-1:0] last_k,
    output logic [IDX_W-1:0] j1,
    output logic [IDX_W-1:0] j2,
    output logic             k_first,
    output logic             k_wrap,
    output logic             fwd,
    output logic             final_it
);
    logic [IDX_W-1:0] k_q;
    logic [IDX_W-1:0] j1_q;

    // Advance inner count and primary index on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            k_q  <= '0;
            j1_q <= '0;
        end else if (step) begin
            if (k_q == last_k) begin
                k_q  <= '0;
                j1_q <= j1_q + 1'b1;
            end else begin
                k_q <= k_q + 1'b1;
            end
        end
    end

    // Derive partner index and position flags.
    always_comb begin
        j1       = j1_q;
        j2       = (k_q >= j1_q) ? k_q + 1'b1 : k_q;
        k_first  = (k_q == '0);
        k_wrap   = (k_q == last_k);
        fwd      = (j1 < j2);
        final_it = k_wrap && (j1_q == last_k + 1'b1);
    end
endmodule

// File: rtl/fpair_accum.sv
// Per-particle and energy accumulation. Contributions are sign-extended to
// ACC_W. The particle sum restarts on k_first and is presented after k_wrap;
// energy adds only forward, in-cutoff pairs. Assumes ACC_W > DATA_W.
module fpair_accum #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_force,
    input  logic signed [DATA_W-1:0] in_energy,
    input  logic                     in_cut,
    input  logic                     k_first,
    input  logic                     k_wrap,
    input  logic                     fwd,
    input  logic [IDX_W-1:0]         j1,
    input  logic                     finish,
    output logic                     part_valid,
    output logic [IDX_W-1:0]         part_idx,
    output logic signed [ACC_W-1:0]  part_sum,
    output logic                     energy_valid,
    output logic signed [ACC_W-1:0]  energy_sum
);
    localparam int EXT_W = ACC_W - DATA_W;

    logic signed [ACC_W-1:0] force_ext;
    logic signed [ACC_W-1:0] energy_ext;
    logic signed [ACC_W-1:0] run_q;
    logic signed [ACC_W-1:0] run_next;

    // Sign-extend inputs and form the next running particle sum.
    always_comb begin
        force_ext  = {{EXT_W{in_force[DATA_W-1]}}, in_force};
        energy_ext = {{EXT_W{in_energy[DATA_W-1]}}, in_energy};
        run_next   = (k_first ? '0 : run_q) + force_ext;
    end

    // Running particle sum and its one-cycle presentation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= '0;
            part_valid <= 1'b0;
            part_idx   <= '0;
            part_sum   <= '0;
        end else begin
            part_valid <= 1'b0;
            if (in_valid) begin
                run_q <= run_next;
                if (k_wrap) begin
                    part_valid <= 1'b1;
                    part_idx   <= j1;
                    part_sum   <= run_next;
                end
            end
        end
    end

    // Energy total: cleared at start, finalized by finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            energy_sum   <= '0;
            energy_valid <= 1'b0;
        end else begin
            energy_valid <= finish;
            if (clear) begin
                energy_sum <= '0;
            end else if (in_valid && fwd && in_cut) begin
                energy_sum <= energy_sum + energy_ext;
            end
        end
    end
endmodule

// File: rtl/pair_loop_fuser.sv
// Top: issues N*(N-1) index pairs under a valid/ready handshake and tracks
// the in-order returned contributions with a second walker. Assumes the
// return stream carries exactly one result per accepted pair, never ahead
// of issue, and always accepts it.
module pair_loop_fuser
    import fpair_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [IDX_W-1:0]         n_count,
    input  logic                     pair_ready,
    input  logic                     res_in_valid,
    input  logic signed [DATA_W-1:0] res_in_force,
    input  logic signed [DATA_W-1:0] res_in_energy,
    input  logic                     res_in_cut,
    output logic                     pair_valid,
    output logic [IDX_W-1:0]         pair_j1,
    output logic [IDX_W-1:0]         pair_j2,
    output logic                     part_valid,
    output logic [IDX_W-1:0]         part_idx,
    output logic signed [ACC_W-1:0]  part_sum,
    output logic                     energy_valid,
    output logic signed [ACC_W-1:0]  energy_sum,
    output logic                     done,
    output logic                     busy
);
    seq_state_t       state_q;
    logic [IDX_W-1:0] last_k_q;
    logic             start_go, start_empty;
    logic             iss_step, trk_step, trk_last;
    logic             iss_first, iss_wrap, iss_fwd, iss_final;
    logic [IDX_W-1:0] trk_j1, trk_j2;
    logic             trk_first, trk_wrap, trk_fwd, trk_final;
    logic             unused_walker_bits;

    // Start decode and handshake steps.
    always_comb begin
        start_go    = start && (state_q == ST_IDLE) && (n_count >= IDX_W'(2));
        start_empty = start && (state_q == ST_IDLE) && (n_count <  IDX_W'(2));
        pair_valid  = (state_q == ST_ISSUE);
        iss_step    = pair_valid && pair_ready;
        trk_step    = res_in_valid && ((state_q == ST_ISSUE) || (state_q == ST_DRAIN));
        trk_last    = trk_step && trk_final;
        busy        = (state_q != ST_IDLE);
    end

    assign unused_walker_bits = &{1'b0, iss_first, iss_wrap, iss_fwd, trk_j2};

    // Capture N-2 at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_k_q <= '0;
        end else if (start_go) begin
            last_k_q <= n_count - IDX_W'(2);
        end
    end

    // Run control: issue, drain outstanding results, flush energy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_go)         state_q <= ST_ISSUE;
                    else if (start_empty) state_q <= ST_FLUSH;
                end
                ST_ISSUE: begin
                    if (trk_last)                    state_q <= ST_FLUSH;
                    else if (iss_step && iss_final)  state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (trk_last) state_q <= ST_FLUSH;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Done pulse one cycle after the energy result.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state_q == ST_FLUSH);
    end

    fpair_walker #(.IDX_W(IDX_W)) u_issue (
        .clk(clk), .rst_n(rst_n), .load(start_go), .step(iss_step),
        .last_k(last_k_q), .j1(pair_j1), .j2(pair_j2),
        .k_first(iss_first), .k_wrap(iss_wrap), .fwd(iss_fwd),
        .final_it(iss_final)
    );

    fpair_walker #(.IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n), .load(start_go), .step(trk_step),
        .last_k(last_k_q), .j1(trk_j1), .j2(trk_j2),
        .k_first(trk_first), .k_wrap(trk_wrap), .fwd(trk_fwd),
        .final_it(trk_final)
    );

    fpair_accum #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(start_go || start_empty),
        .in_valid(trk_step), .in_force(res_in_force),
        .in_energy(res_in_energy), .in_cut(res_in_cut),
        .k_first(trk_first), .k_wrap(trk_wrap), .fwd(trk_fwd), .j1(trk_j1),
        .finish(trk_last || start_empty),
        .part_valid(part_valid), .part_idx(part_idx), .part_sum(part_sum),
        .energy_valid(energy_valid), .energy_sum(energy_sum)
    );
endmodule

// File: rtl/pair_loop_fuser_chk.sv
// Protocol checker for pair_loop_fuser, attached by bind.
module pair_loop_fuser_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             pair_valid,
    input logic             pair_ready,
    input logic [IDX_W-1:0] pair_j1,
    input logic [IDX_W-1:0] pair_j2,
    input logic             energy_valid,
    input logic             done
);
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid && !pair_ready |=> pair_valid && $stable(pair_j1) && $stable(pair_j2));
    a_r4_partner_skips: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> pair_j1 != pair_j2);
    a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        energy_valid |=> done);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pair_valid);
endmodule

bind pair_loop_fuser pair_loop_fuser_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .pair_valid(pair_valid),
    .pair_ready(pair_ready), .pair_j1(pair_j1), .pair_j2(pair_j2),
    .energy_valid(energy_valid), .done(done)
);

// File: tb/sim_pair_loop_fuser.sv
module sim_pair_loop_fuser;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] n_count = '0;
    logic pair_ready = 1'b0;
    logic res_in_valid = 1'b0;
    logic signed [31:0] res_in_force = '0;
    logic signed [31:0] res_in_energy = '0;
    logic res_in_cut = 1'b0;
    logic pair_valid;
    logic [7:0] pair_j1, pair_j2;
    logic part_valid;
    logic [7:0] part_idx;
    logic signed [39:0] part_sum;
    logic energy_valid;
    logic signed [39:0] energy_sum;
    logic done, busy;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pair_loop_fuser u0 (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int f_j1(int i, int n); return i / (n - 1); endfunction
    function automatic int f_j2(int i, int n);
        int r = i % (n - 1);
        return (r >= f_j1(i, n)) ? r + 1 : r;
    endfunction
    function automatic int force_of(int a, int b, bit big);
        return big ? (32'sh7FFF_FF00 + b) : (a * 13 - b * 7 - 3);
    endfunction
    function automatic int energy_of(int a, int b); return b * 9 - a * 4 - 10; endfunction
    function automatic bit cut_of(int a, int b); return ((a + b) % 3) != 0; endfunction

    // One run: stall_mode gives ready gaps, slow_ret returns every other cycle.
    task automatic run_case(input int n, input bit stall_mode, input bit slow_ret,
                            input bit big, input bit poke);
        int iss = 0, ret = 0, parts = 0, cyc = 0, iss_before;
        longint macc = 0, men = 0;
        bit exp_pv = 0, exp_ev = 0, exp_done = 0, seen_done = 0;
        bit nxt_pv, nxt_ev, held = 0, rdy;
        int exp_pidx = 0, nxt_pidx = 0, held_j1 = 0, held_j2 = 0;
        longint exp_psum = 0, exp_esum = 0, nxt_psum = 0, nxt_esum = 0;
        @(negedge clk);
        start = 1'b1; n_count = 8'(n);
        exp_ev = 0;
        nxt_ev = (n < 2);
        exp_ev = 0;
        @(negedge clk);
        start = 1'b0; n_count = 8'hAA;
        exp_ev = nxt_ev; exp_esum = 0;
        while (!seen_done && cyc < 4000) begin
            // sample and compare
            if (held) chk(pair_valid && pair_j1 == 8'(held_j1) && pair_j2 == 8'(held_j2),
                          "R5 stall hold", longint'(pair_j1), held_j1);
            if (part_valid || exp_pv) begin
                chk(part_valid == exp_pv && part_idx == 8'(exp_pidx),
                    "R6 part idx", longint'(part_idx), exp_pidx);
                chk(longint'(part_sum) == exp_psum, big ? "R7 wide sum" : "R6 part sum",
                    longint'(part_sum), exp_psum);
                parts++;
            end
            if (energy_valid || exp_ev)
                chk(energy_valid == exp_ev && longint'(energy_sum) == exp_esum,
                    n < 2 ? "R10 empty energy" : "R8 energy", longint'(energy_sum), exp_esum);
            if (done || exp_done) begin
                chk(done == exp_done && !busy, n < 2 ? "R10 done" : "R9 done",
                    longint'(done), longint'(exp_done));
                seen_done = done;
            end
            if (seen_done) break;
            // stimulus for this cycle
            exp_done = exp_ev;
            nxt_pv = 0; nxt_ev = 0;
            start = (poke && cyc == 4); n_count = start ? 8'd3 : 8'hAA;
            rdy = stall_mode ? ((cyc % 3) != 1) : 1'b1;
            pair_ready = rdy;
            iss_before = iss;
            held = 0;
            if (pair_valid && rdy) begin
                chk(int'(pair_j1) == f_j1(iss, n) && int'(pair_j2) == f_j2(iss, n),
                    "R3 order", longint'({pair_j1, pair_j2}),
                    longint'({8'(f_j1(iss, n)), 8'(f_j2(iss, n))}));
                if (pair_j1 == pair_j2) chk(0, "R4 skip", pair_j2, -1);
                iss++;
            end else if (pair_valid) begin
                held = 1; held_j1 = pair_j1; held_j2 = pair_j2;
            end
            if (n >= 2 && ret < iss_before && (!slow_ret || cyc % 2 == 0)) begin
                int a = f_j1(ret, n), b = f_j2(ret, n), k = ret % (n - 1);
                res_in_valid  = 1'b1;
                res_in_force  = force_of(a, b, big);
                res_in_energy = energy_of(a, b);
                res_in_cut    = cut_of(a, b);
                macc = (k == 0 ? 0 : macc) + longint'(force_of(a, b, big));
                if (a < b && cut_of(a, b)) men += energy_of(a, b);
                if (k == n - 2) begin nxt_pv = 1; nxt_pidx = a; nxt_psum = macc; end
                if (ret == n * (n - 1) - 1) begin nxt_ev = 1; nxt_esum = men; end
                ret++;
            end else begin
                res_in_valid = 1'b0;
            end
            @(negedge clk);
            exp_pv = nxt_pv; exp_pidx = nxt_pidx; exp_psum = nxt_psum;
            exp_ev = nxt_ev; exp_esum = nxt_esum;
            cyc++;
        end
        res_in_valid = 1'b0; start = 1'b0;
        chk(seen_done, "R9 run ends", cyc, 0);
        chk(iss == (n < 2 ? 0 : n * (n - 1)), poke ? "R2 start ignored" : "R3 pair count",
            iss, n < 2 ? 0 : n * (n - 1));
        chk(parts == (n < 2 ? 0 : n), "R6 part count", parts, n < 2 ? 0 : n);
        chk(!pair_valid && !busy, "R3 idle after run", pair_valid, 0);
    endtask

    task automatic t_reset();
        chk(!pair_valid && !part_valid && !energy_valid && !done && !busy,
            "R1 reset", {pair_valid, part_valid, energy_valid, done, busy}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk); rst_n = 1'b1;
        run_case(4, 0, 0, 0, 0);   // R3 R6 R8 baseline
        run_case(5, 1, 1, 0, 0);   // R5 stalls, delayed returns
        run_case(4, 0, 0, 1, 0);   // R7 wide sums
        run_case(4, 1, 0, 0, 1);   // R2 start while busy
        run_case(2, 0, 1, 0, 0);   // smallest real run
        run_case(1, 0, 0, 0, 0);   // R10
        run_case(0, 0, 0, 0, 0);   // R10
        run_case(6, 1, 1, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule